// File: doc/BRIEF.md
# Dual-Lane DDR Byte Deinterleaver

This block sits behind a 16-bit parallel data port that runs as two 8-bit byte lanes clocked on both phases of a forwarded data clock. Each sample reaches the block in two halves. Its most significant byte comes during the high phase of the data clock, and its least significant byte comes during the following low phase. A frame input travels with the data. It chooses which pair of output channels the two lanes feed: channels 1 and 3, or channels 2 and 4. The block joins each high/low byte pair into a full word. It then places that word on one of four channel outputs and pulses that channel's valid strobe.

For simulation, the double-rate capture is modelled with a system clock at twice the data-clock rate. On each system clock edge the block samples the level of the data clock, which tells it which byte phase is present. There are two optional settings. One reverses the bit order inside every byte lane, for senders that transmit least-significant-bit first. The other inverts the sampled data-clock phase, to correct a skew between clock and data. Both settings are taken only when a load strobe is present, so a sample is never split across two settings.

Top module: `byte_ddr_deint`

## Requirements
- R1: A byte pair is captured in the cycle where the effective phase (`dci` XOR the loaded invert bit) is 1. The word is assembled at the next cycle whose effective phase is 0. The assembled word is {high-phase byte, low-phase byte} for each lane.
- R2: With `frame` = 1, the upper lane `din[15:8]` feeds `ch1_data` and the lower lane `din[7:0]` feeds `ch3_data`.
- R3: With `frame` = 0, the upper lane feeds `ch2_data` and the lower lane feeds `ch4_data`.
- R4: `ch_valid[0..3]` belongs to channels 1..4. In the cycle after an assembly, the two strobes of the updated pair are 1 for exactly one cycle. Otherwise they are 0, and each channel output holds its value.
- R5: If `frame` during the low byte differs from `frame` during the high byte, nothing is written and `frame_err` goes to 1. It stays at 1 until reset.
- R6: With the loaded swap bit set, bit i of every byte lane is taken as bit 7-i, for both the high and the low byte.
- R7: With the loaded invert bit set, `dci` = 0 marks the high-byte phase and `dci` = 1 marks the low-byte phase.
- R8: `cfg_swap` and `cfg_inv` take effect only through a clock edge where `cfg_load` = 1. At any other time their values have no effect on the outputs.
- R9: Reset clears all channel outputs, the strobes, `frame_err` and both settings. A low phase that arrives before any high phase has been captured is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the data-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| dci | input | 1 | Sampled level of the forwarded data clock |
| frame | input | 1 | Channel-pair select travelling with the data |
| din | input | 16 | Two byte lanes, upper and lower |
| cfg_load | input | 1 | Load strobe for the two settings |
| cfg_swap | input | 1 | Bit-reversal setting for each lane |
| cfg_inv | input | 1 | Capture phase inversion setting |
| ch1_data | output | 16 | Channel 1 word |
| ch2_data | output | 16 | Channel 2 word |
| ch3_data | output | 16 | Channel 3 word |
| ch4_data | output | 16 | Channel 4 word |
| ch_valid | output | 4 | Per-channel one-cycle update strobes |
| frame_err | output | 1 | Sticky frame mismatch flag |

## Verification
The bench builds the block with its default lane width of 8. At that width every output word can be predicted by hand from the two lane bytes, and a bit reversal inside a byte is easy to see in hexadecimal values. This width covers both frame values under the normal and the inverted capture phase, a swap setting that is present but never loaded, and a mismatch between high and low frame. Each case is checked against all four channel outputs at once, so an update that reaches the wrong pair shows up as a failure.

// File: rtl/byte_ddr_deint.sv
module byte_ddr_deint #(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dci,
  input  logic                  frame,
  input  logic [2*LANE_W-1:0]   din,
  input  logic                  cfg_load,
  input  logic                  cfg_swap,
  input  logic                  cfg_inv,
  output logic [2*LANE_W-1:0]   ch1_data,
  output logic [2*LANE_W-1:0]   ch2_data,
  output logic [2*LANE_W-1:0]   ch3_data,
  output logic [2*LANE_W-1:0]   ch4_data,
  output logic [3:0]            ch_valid,
  output logic                  frame_err
);
  localparam int WORD_W = 2 * LANE_W;

  function automatic logic [LANE_W-1:0] rev_bits(input logic [LANE_W-1:0] b);
    logic [LANE_W-1:0] r;
    for (int i = 0; i < LANE_W; i++) r[i] = b[LANE_W-1-i];
    return r;
  endfunction

  logic              swap_q, inv_q, have_hi, hi_frame;
  logic [WORD_W-1:0] hi_q;

  wire               phase_hi = dci ^ inv_q;
  wire [LANE_W-1:0]  up_b = swap_q ? rev_bits(din[WORD_W-1:LANE_W]) : din[WORD_W-1:LANE_W];
  wire [LANE_W-1:0]  lo_b = swap_q ? rev_bits(din[LANE_W-1:0]) : din[LANE_W-1:0];
  wire [WORD_W-1:0]  up_word = {hi_q[WORD_W-1:LANE_W], up_b};
  wire [WORD_W-1:0]  lo_word = {hi_q[LANE_W-1:0], lo_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swap_q    <= 1'b0;
      inv_q     <= 1'b0;
      have_hi   <= 1'b0;
      hi_frame  <= 1'b0;
      hi_q      <= '0;
      ch1_data  <= '0;
      ch2_data  <= '0;
      ch3_data  <= '0;
      ch4_data  <= '0;
      ch_valid  <= '0;
      frame_err <= 1'b0;
    end else begin
      if (cfg_load) begin
        swap_q <= cfg_swap;
        inv_q  <= cfg_inv;
      end
      ch_valid <= '0;
      if (phase_hi) begin
        hi_q     <= {up_b, lo_b};
        hi_frame <= frame;
        have_hi  <= 1'b1;
      end else if (have_hi) begin
        have_hi <= 1'b0;
        if (frame != hi_frame) begin
          frame_err <= 1'b1;
        end else if (hi_frame) begin
          ch1_data <= up_word;
          ch3_data <= lo_word;
          ch_valid <= 4'b0101;
        end else begin
          ch2_data <= up_word;
          ch4_data <= lo_word;
          ch_valid <= 4'b1010;
        end
      end
    end
  end
endmodule

module byte_ddr_deint_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_load,
  input logic                swap_q,
  input logic                inv_q,
  input logic [2*LANE_W-1:0] ch1_data,
  input logic [2*LANE_W-1:0] ch2_data,
  input logic [2*LANE_W-1:0] ch3_data,
  input logic [2*LANE_W-1:0] ch4_data,
  input logic [3:0]          ch_valid,
  input logic                frame_err
);
  AST_VALID_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid != 4'b0) |-> (ch_valid == 4'b0101 || ch_valid == 4'b1010)); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid != 4'b0) |=> (ch_valid == 4'b0)); // R4
  AST_HOLD_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_data != $past(ch1_data)) |-> ch_valid[0]); // R4
  AST_HOLD_CH2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch2_data != $past(ch2_data)) |-> ch_valid[1]); // R3
  AST_HOLD_CH4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch4_data != $past(ch4_data)) |-> ch_valid[3]); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(swap_q) && $stable(inv_q))); // R8
endmodule

bind byte_ddr_deint byte_ddr_deint_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .swap_q(swap_q), .inv_q(inv_q),
  .ch1_data(ch1_data), .ch2_data(ch2_data), .ch3_data(ch3_data), .ch4_data(ch4_data),
  .ch_valid(ch_valid), .frame_err(frame_err)
);

// File: tb/tb_byte_ddr_deint.sv
module tb_byte_ddr_deint;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dci = 1'b0, frame = 1'b0, cfg_load = 1'b0, cfg_swap = 1'b0, cfg_inv = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] ch1_data, ch2_data, ch3_data, ch4_data;
  logic [3:0]  ch_valid;
  logic        frame_err;

  int total = 0, bad = 0;
  bit inv_b = 1'b0;
  logic [15:0] exp_ch [4] = '{default: 16'h0};

  always #2 clk = ~clk;

  byte_ddr_deint dut (
    .clk(clk), .rst_n(rst_n), .dci(dci), .frame(frame), .din(din),
    .cfg_load(cfg_load), .cfg_swap(cfg_swap), .cfg_inv(cfg_inv),
    .ch1_data(ch1_data), .ch2_data(ch2_data), .ch3_data(ch3_data), .ch4_data(ch4_data),
    .ch_valid(ch_valid), .frame_err(frame_err)
  );

  // {frame, high word, low word, expected upper-lane channel, expected lower-lane channel}
  localparam logic [64:0] VEC [0:3] = '{
    {1'b1, 16'h1234, 16'h5678, 16'h1256, 16'h3478},
    {1'b0, 16'hABCD, 16'hEF01, 16'hABEF, 16'hCD01},
    {1'b1, 16'hFF00, 16'h00FF, 16'hFF00, 16'h00FF},
    {1'b0, 16'h8001, 16'h7F80, 16'h807F, 16'h0180}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic d, logic f, logic [15:0] x);
    @(negedge clk);
    dci = d; frame = f; din = x;
  endtask

  task automatic idle();
    drive(inv_b, 1'b0, 16'h0);
  endtask

  task automatic check_all(string req, logic [3:0] vexp);
    chk(req, {28'h0, ch_valid}, {28'h0, vexp});
    chk(req, {16'h0, ch1_data}, {16'h0, exp_ch[0]});
    chk(req, {16'h0, ch2_data}, {16'h0, exp_ch[1]});
    chk(req, {16'h0, ch3_data}, {16'h0, exp_ch[2]});
    chk(req, {16'h0, ch4_data}, {16'h0, exp_ch[3]});
  endtask

  task automatic send(logic fh, logic fl, logic [15:0] hi, logic [15:0] lo);
    drive(!inv_b, fh, hi);
    drive(inv_b, fl, lo);
    idle();
  endtask

  task automatic load_cfg(bit sw, bit iv);
    @(negedge clk);
    cfg_load = 1'b1; cfg_swap = sw; cfg_inv = iv;
    @(negedge clk);
    cfg_load = 1'b0;
    inv_b = iv;
    dci = iv;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R9 reset", 4'b0000);
    chk("R9 reset err", {31'h0, frame_err}, 32'h0);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 16'hFFFF);
    idle();
    check_all("R9 low before high ignored", 4'b0000);

    for (int i = 0; i < 4; i++) begin
      logic [64:0] v = VEC[i];
      send(v[64], v[64], v[63:48], v[47:32]);
      if (v[64]) begin exp_ch[0] = v[31:16]; exp_ch[2] = v[15:0]; end
      else       begin exp_ch[1] = v[31:16]; exp_ch[3] = v[15:0]; end
      check_all(v[64] ? "R1 R2 frame high pair" : "R1 R3 frame low pair",
                v[64] ? 4'b0101 : 4'b1010);
      idle();
      check_all("R4 hold after strobe", 4'b0000);
    end

    cfg_swap = 1'b1;
    send(1'b1, 1'b1, 16'h0180, 16'h4002);
    exp_ch[0] = 16'h0140; exp_ch[2] = 16'h8002;
    check_all("R8 swap not loaded", 4'b0101);

    load_cfg(1'b1, 1'b0);
    send(1'b1, 1'b1, 16'h0180, 16'h4002);
    exp_ch[0] = 16'h8002; exp_ch[2] = 16'h0140;
    check_all("R6 swap loaded", 4'b0101);

    load_cfg(1'b0, 1'b1);
    send(1'b0, 1'b0, 16'h2468, 16'h1357);
    exp_ch[1] = 16'h2413; exp_ch[3] = 16'h6857;
    check_all("R7 inverted phase", 4'b1010);

    send(1'b1, 1'b0, 16'hAAAA, 16'h5555);
    check_all("R5 mismatch no write", 4'b0000);
    chk("R5 err set", {31'h0, frame_err}, 32'h1);
    idle(); idle();
    chk("R5 err sticky", {31'h0, frame_err}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule